// File: doc/BRIEF.md
# UART Register Front End with Baud Tick Generator

This block sits between a byte-wide register bus and the serial datapaths of a 16550-compatible UART. It decodes a 3-bit register offset, holds the line control byte, an interrupt-enable byte and a 16-bit baud divisor, and drives the read and write strobes that the receive and transmit FIFOs consume. Bit 7 of line control (the divisor access bit) overlays offsets 0 and 1. When that bit is set, those offsets reach the two divisor bytes. When it is clear, offset 0 reaches the receive/transmit data path and offset 1 reaches the interrupt-enable byte.

A 16-bit down-counter produces a one-cycle enable, `baud_en`, at sixteen times the baud rate. The divisor written by software is held in a staging copy. The counter picks it up only at a reload, and only while the access bit is clear. Software therefore sets the access bit, writes both divisor bytes, and then clears the access bit before moving data. The divisor value is the peripheral clock divided by sixteen times the baud rate.

The tick generator is a two-state machine. In HALT there is no tick. The transition START (HALT to RUN) happens when the access bit is clear and the staged divisor is nonzero. In RUN the counter counts down, and on reaching 1 it emits a tick and performs RELOAD (RUN to RUN) from the active divisor. If the access bit is clear at that reload, the staged divisor is applied. If the staged divisor is zero, the transition STOP (RUN to HALT) is taken instead.

Top module: `uart_regbank_baud`

## Requirements
- R1: After reset, line control reads 0 at offset 3. Both divisor bytes read 0, and `baud_en` stays low.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the high byte. Accesses there raise neither `rx_rd_stb` nor `tx_wr_stb`.
- R3: While bit 7 is 0, a read of offset 0 returns `rx_data` on `bus_rdata` and holds `rx_rd_stb` high for exactly the cycles `bus_rd` is high.
- R4: While bit 7 is 0, a write to offset 0 holds `tx_wr_stb` high for that cycle, with `tx_data` equal to `bus_wdata`.
- R5: While bit 7 is 0, offset 1 is an 8-bit interrupt-enable register that reads back what was written. It is separate from the divisor high byte.
- R6: Offset 3 is the 8-bit line control register, readable and writable whatever the value of bit 7.
- R7: With an active divisor N of 1 or more, `baud_en` is high for one cycle in every N. The high byte (offset 1) supplies bits 15:8 of N.
- R8: A divisor written while bit 7 is 1 does not change the tick period. It takes effect at the first reload that happens with bit 7 clear.
- R9: An active divisor of 0 stops `baud_en`. From the stopped state, once bit 7 is 0 and a nonzero divisor N is staged, the first tick comes N cycles after the clock edge that cleared bit 7.
- R10: Offsets 2, 4, 5, 6 and 7 read as 0, and writes to them change no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write enable, one register per cycle |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_rd_stb | output | 1 | Pop strobe to the receive FIFO |
| tx_wr_stb | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | 8 | Byte pushed to the transmit FIFO |
| baud_en | output | 1 | One-cycle enable at sixteen times the baud rate |

## Verification
The hardest case to reach from the ports is a divisor rewrite while the counter is running. The staged divisor and the active divisor then differ, and the tick period has to keep its old value until a reload that sees the access bit clear. The stimulus first starts the counter at a small period. It then sets the access bit and writes a different divisor, measures several periods to confirm that nothing has changed yet, and finally clears the bit and measures the period that follows the next tick. The stopped state is reached the same way, by staging a zero divisor, and is left again by staging a nonzero one.

// File: rtl/uart_rb_pkg.sv
`timescale 1ns/1ps
package uart_rb_pkg;

    // Register offsets whose meaning the other logic depends on
    localparam int OFS_DATA = 0;   // data path, or divisor low byte when access bit set
    localparam int OFS_IEN  = 1;   // interrupt enable, or divisor high byte when access bit set
    localparam int OFS_LCTL = 3;   // line control
    localparam int ACC_BIT  = 7;   // divisor access bit inside line control

    typedef enum logic [0:0] {
        BG_HALT = 1'b0,
        BG_RUN  = 1'b1
    } baud_state_e;

endpackage

// File: rtl/uart_rb_regs.sv
`timescale 1ns/1ps
module uart_rb_regs
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rx_rd_stb,
    output logic              tx_wr_stb,
    output logic [DATA_W-1:0] lctl_q,
    output logic [DIV_W-1:0]  div_stage
);

    localparam int DIV_BYTES = DIV_W / DATA_W;

    logic              acc;
    logic              hit_data;
    logic [DATA_W-1:0] ien_q;

    assign acc      = lctl_q[ACC_BIT];
    assign hit_data = (bus_addr == ADDR_W'(OFS_DATA)) && !acc;

    // One staging byte per divisor slice; slice i is at offset i while the access bit is set
    for (genvar gi = 0; gi < DIV_BYTES; gi++) begin : g_div
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                div_stage[gi*DATA_W +: DATA_W] <= '0;
            end else if (bus_wr && acc && (bus_addr == ADDR_W'(gi))) begin
                div_stage[gi*DATA_W +: DATA_W] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lctl_q <= '0;
        end else if (bus_wr && (bus_addr == ADDR_W'(OFS_LCTL))) begin
            lctl_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (bus_wr && !acc && (bus_addr == ADDR_W'(OFS_IEN))) begin
            ien_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (acc && (int'(bus_addr) < DIV_BYTES)) begin
            bus_rdata = div_stage[int'(bus_addr)*DATA_W +: DATA_W];
        end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
            bus_rdata = rx_data;
        end else if (bus_addr == ADDR_W'(OFS_IEN)) begin
            bus_rdata = ien_q;
        end else if (bus_addr == ADDR_W'(OFS_LCTL)) begin
            bus_rdata = lctl_q;
        end
    end

    assign rx_rd_stb = bus_rd && hit_data;
    assign tx_wr_stb = bus_wr && hit_data;

endmodule

// File: rtl/uart_rb_baudgen.sv
`timescale 1ns/1ps
module uart_rb_baudgen
    import uart_rb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [DIV_W-1:0] div_stage,
    output logic             baud_en,
    output logic [DIV_W-1:0] act_div
);

    baud_state_e      state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] act_q, act_d;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BG_HALT;
            cnt_q   <= '0;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        baud_en = 1'b0;
        unique case (state_q)
            BG_HALT: begin
                if (!acc && (div_stage != '0)) begin      // START
                    act_d   = div_stage;
                    cnt_d   = div_stage;
                    state_d = BG_RUN;
                end
            end
            BG_RUN: begin
                if (cnt_q == DIV_W'(1)) begin
                    baud_en = 1'b1;
                    if (acc) begin                         // RELOAD, old divisor
                        cnt_d = act_q;
                    end else begin
                        act_d = div_stage;
                        if (div_stage == '0) begin         // STOP
                            state_d = BG_HALT;
                        end else begin                     // RELOAD, staged divisor
                            cnt_d = div_stage;
                        end
                    end
                end else begin
                    cnt_d = cnt_q - DIV_W'(1);
                end
            end
            default: state_d = BG_HALT;
        endcase
    end

    assign act_div = act_q;

endmodule

// File: rtl/uart_regbank_baud.sv
`timescale 1ns/1ps
module uart_regbank_baud
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_rd_stb,
    output logic              tx_wr_stb,
    output logic [DATA_W-1:0] tx_data,
    output logic              baud_en
);

    localparam int DIV_W = 2 * DATA_W;

    logic [DATA_W-1:0] lctl_val;
    logic [DIV_W-1:0]  div_stage;
    logic [DIV_W-1:0]  act_div;

    uart_rb_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .rx_data   (rx_data),
        .bus_rdata (bus_rdata),
        .rx_rd_stb (rx_rd_stb),
        .tx_wr_stb (tx_wr_stb),
        .lctl_q    (lctl_val),
        .div_stage (div_stage)
    );

    uart_rb_baudgen #(
        .DIV_W (DIV_W)
    ) bgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (lctl_val[ACC_BIT]),
        .div_stage (div_stage),
        .baud_en   (baud_en),
        .act_div   (act_div)
    );

    assign tx_data = bus_wdata;

endmodule

// File: rtl/uart_regbank_baud_chk.sv
`timescale 1ns/1ps
module uart_regbank_baud_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              tx_wr_stb,
    input logic              baud_en,
    input logic [DATA_W-1:0] lctl_val,
    input logic [DIV_W-1:0]  act_div
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lctl_val == '0 && act_div == '0 && !baud_en)); // R1

    AST_DIV_WRITE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && lctl_val[DATA_W-1]) |-> !tx_wr_stb); // R2

    AST_LCTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(lctl_val)); // R6

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        baud_en |=> (!baud_en || act_div == DIV_W'(1))); // R7

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lctl_val[DATA_W-1] |=> $stable(act_div)); // R8

    AST_ZERO_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == '0) |-> !baud_en); // R9

endmodule

bind uart_regbank_baud uart_regbank_baud_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .tx_wr_stb (tx_wr_stb),
    .baud_en   (baud_en),
    .lctl_val  (lctl_val),
    .act_div   (act_div)
);

// File: tb/uart_regbank_baud_tb_top.sv
`timescale 1ns/1ps
module uart_regbank_baud_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] rx_data = '0;
    logic       rx_rd_stb;
    logic       tx_wr_stb;
    logic [7:0] tx_data;
    logic       baud_en;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    uart_regbank_baud dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_data   (rx_data),
        .rx_rd_stb (rx_rd_stb),
        .tx_wr_stb (tx_wr_stb),
        .tx_data   (tx_data),
        .baud_en   (baud_en)
    );

    // Vector: {is_read, offset, data (write value or expected read), requirement}
    localparam int NV = 18;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 3'd3, 8'h80, 4'd6},   // access bit on
        {1'b0, 3'd0, 8'h34, 4'd2},   // R2 low byte
        {1'b0, 3'd1, 8'h12, 4'd2},   // R2 high byte
        {1'b1, 3'd0, 8'h34, 4'd2},
        {1'b1, 3'd1, 8'h12, 4'd2},
        {1'b1, 3'd3, 8'h80, 4'd6},   // R6
        {1'b0, 3'd3, 8'h1B, 4'd6},   // access bit off
        {1'b1, 3'd3, 8'h1B, 4'd6},
        {1'b0, 3'd1, 8'h0F, 4'd5},   // R5 interrupt enable
        {1'b1, 3'd1, 8'h0F, 4'd5},
        {1'b0, 3'd5, 8'hAA, 4'd10},  // R10 unused offsets
        {1'b0, 3'd7, 8'h55, 4'd10},
        {1'b1, 3'd5, 8'h00, 4'd10},
        {1'b1, 3'd2, 8'h00, 4'd10},
        {1'b1, 3'd3, 8'h1B, 4'd10},
        {1'b0, 3'd3, 8'h80, 4'd6},
        {1'b1, 3'd1, 8'h12, 4'd5},   // divisor high untouched by enable write
        {1'b1, 3'd0, 8'h34, 4'd5}
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d, output logic stb);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d   = bus_rdata;
        stb = rx_rd_stb;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] n);
        bus_write(3'd3, 8'h80);
        bus_write(3'd0, n[7:0]);
        bus_write(3'd1, n[15:8]);
        bus_write(3'd3, 8'h03);
    endtask

    // Called at a negedge; k counts negedges until baud_en is seen high
    task automatic wait_tick(input int limit, output int k);
        k = 0;
        while (!baud_en && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic period(input int limit, output int p);
        int k;
        @(negedge clk);
        wait_tick(limit, k);
        p = k + 1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       stb;
        int         k;
        int         p;
        int         cnt;

        do_reset();

        // R1 reset state
        bus_read(3'd3, rd, stb);
        chk(rd == 8'h00, "R1 line control", rd, 0);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (baud_en) cnt++;
        end
        chk(cnt == 0, "R1 no tick after reset", cnt, 0);
        bus_write(3'd3, 8'h80);
        bus_read(3'd0, rd, stb);
        chk(rd == 8'h00, "R1 divisor low", rd, 0);
        bus_read(3'd1, rd, stb);
        chk(rd == 8'h00, "R1 divisor high", rd, 0);
        bus_write(3'd3, 8'h00);

        // Register vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][15]) begin
                bus_read(VEC[i][14:12], rd, stb);
                chk(rd == VEC[i][11:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i), rd, VEC[i][11:4]);
            end else begin
                bus_write(VEC[i][14:12], VEC[i][11:4]);
            end
        end

        // R2 no strobes for divisor access (access bit set by the table)
        rx_data = 8'hC5;
        bus_read(3'd0, rd, stb);
        chk(stb == 1'b0, "R2 no pop on divisor read", stb, 0);
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h34; bus_wr = 1'b1;
        #1;
        chk(tx_wr_stb == 1'b0, "R2 no push on divisor write", tx_wr_stb, 0);
        @(negedge clk);
        bus_wr = 1'b0;

        // R3 data read pops the receive FIFO
        bus_write(3'd3, 8'h03);
        bus_read(3'd0, rd, stb);
        chk(rd == 8'hC5, "R3 read data", rd, 8'hC5);
        chk(stb == 1'b1, "R3 pop strobe", stb, 1);
        #1;
        chk(rx_rd_stb == 1'b0, "R3 pop strobe ends", rx_rd_stb, 0);

        // R4 data write pushes the transmit FIFO
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h5A; bus_wr = 1'b1;
        #1;
        chk(tx_wr_stb == 1'b1, "R4 push strobe", tx_wr_stb, 1);
        chk(tx_data == 8'h5A, "R4 push data", tx_data, 8'h5A);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk(tx_wr_stb == 1'b0, "R4 push strobe ends", tx_wr_stb, 0);

        // Tick behaviour from a clean start
        do_reset();
        set_div(16'd4);
        wait_tick(50, k);
        chk(k == 4, "R9 first tick latency N=4", k, 4);
        period(50, p);
        chk(p == 4, "R7 period N=4", p, 4);
        period(50, p);
        chk(p == 4, "R7 period N=4 again", p, 4);

        // R8 staged divisor held back while access bit set
        bus_write(3'd3, 8'h80);
        bus_write(3'd0, 8'd7);
        for (int i = 0; i < 3; i++) begin
            period(50, p);
            chk(p == 4, "R8 period unchanged while access set", p, 4);
        end
        bus_write(3'd3, 8'h03);
        wait_tick(50, k);
        period(50, p);
        chk(p == 7, "R8 new divisor after access cleared", p, 7);

        // R7 high byte contributes
        set_div(16'h0103);
        wait_tick(50, k);
        period(400, p);
        chk(p == 259, "R7 period N=0x103", p, 259);

        // R7 divisor of one
        set_div(16'd1);
        wait_tick(400, k);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (baud_en) cnt++;
        end
        chk(cnt == 5, "R7 tick every cycle N=1", cnt, 5);

        // R9 zero divisor stops, restart from stop
        set_div(16'd0);
        repeat (10) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (baud_en) cnt++;
        end
        chk(cnt == 0, "R9 stopped with zero divisor", cnt, 0);
        set_div(16'd6);
        wait_tick(50, k);
        chk(k == 6, "R9 restart latency N=6", k, 6);
        period(50, p);
        chk(p == 6, "R9 restart period N=6", p, 6);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule